// File: doc/BRIEF.md
# Load-Use Pipeline Interlock

This block is the hazard detector for an in-order, single-issue pipeline with fetch, decode, ALU and writeback stages. Load results arrive later than ALU results: a load finishes in seven cycles and an ALU operation in four. As a result, the three instructions that follow a load cannot yet see the loaded value.

The block keeps one small down-counter per general-purpose register. When a load leaves decode, the counter of the load's target register is loaded with the size of that shadow. The counter then counts down once per clock. While the counter is nonzero, the register is reported as busy.

The instruction in decode presents the following fields:
- two source specifiers, each with its own enable;
- a target specifier, with a flag that says whether the target is also read (a two-address operation, or the data register of a store);
- a load flag;
- a valid bit.

If any field that is actually read names a busy register, the block raises a stall. During a stall, decode holds its instruction and a bubble goes into the ALU stage. The counters keep running while the pipeline is stalled, so the stall lasts exactly until the data is usable.

Top module: `load_use_interlock`

## Requirements
- R1: After reset no register is busy, stall is low, and issue follows the valid input.
- R2: When a load issues, its target register is busy for exactly the next 3 clock cycles (load latency 7 minus ALU latency 4), and then free. At most 3 registers are ever busy at once.
- R3: A valid instruction whose first or second source field is enabled and names a busy register asserts stall.
- R4: When the target-read flag is set (two-address operation or store data register), a busy register in the target field asserts stall.
- R5: A source field whose enable is low, or a target field whose read flag is low, never causes a stall, even if it names a busy register.
- R6: An instruction that reads a load's target at distance d (1 to 3) behind the load stalls for exactly 4-d cycles. At distance 4 or more it issues without a stall.
- R7: issue equals valid and not stall. Countdowns continue to decrement while stalled, and a stalled instruction does not issue.
- R8: A load marks its target busy only in the cycle it issues. A load that is stalled or not valid marks nothing.
- R9: A second load to a register that is still busy restarts that register's window at 3 cycles.
- R10: The busy output bit k reflects register k, for all 16 registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_load | input | 1 | Instruction in decode is a load |
| src_a | input | 4 | First source register |
| src_a_en | input | 1 | First source is read |
| src_b | input | 4 | Second source register |
| src_b_en | input | 1 | Second source is read |
| dst | input | 4 | Target register (load destination, two-address operand, store data) |
| dst_rd_en | input | 1 | Target field is also read |
| stall | output | 1 | Hold decode and insert a bubble into the ALU stage |
| issue | output | 1 | Decode instruction moves to the ALU stage this cycle |
| busy | output | 16 | Per-register pending-load flags |

## Verification
The bench checks dependents at distances one to four behind a load. A counter that is set one cycle too short or too long shows up as a stall count off by one at these distances. A design that froze its counters during a stall would hang for a longer time.

Each operand path is checked on its own, including paths whose enable is low: a missing or ungated comparison shows up as a wrong stall. Stalled loads and invalid loads are sent in, which exposes a design that marks the target without checking issue. Back-to-back loads to the same register expose a window that is not restarted.

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int NREG     = 16,
  parameter int LOAD_LAT = 7,
  parameter int ALU_LAT  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dec_valid,
  input  logic                    dec_load,
  input  logic [$clog2(NREG)-1:0] src_a,
  input  logic                    src_a_en,
  input  logic [$clog2(NREG)-1:0] src_b,
  input  logic                    src_b_en,
  input  logic [$clog2(NREG)-1:0] dst,
  input  logic                    dst_rd_en,
  output logic                    stall,
  output logic                    issue,
  output logic [NREG-1:0]         busy
);
  localparam int AW  = $clog2(NREG);
  localparam int WIN = LOAD_LAT - ALU_LAT;
  localparam int CW  = $clog2(WIN + 1);

  logic [CW-1:0] cnt [NREG];
  logic          hit_a, hit_b, hit_d, load_go;

  assign hit_a   = src_a_en  & busy[src_a];
  assign hit_b   = src_b_en  & busy[src_b];
  assign hit_d   = dst_rd_en & busy[dst];
  assign stall   = dec_valid & (hit_a | hit_b | hit_d);
  assign issue   = dec_valid & ~stall;
  assign load_go = issue & dec_load;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic set_i;
    assign set_i   = load_go && (dst == AW'(i));
    assign busy[i] = |cnt[i];

    always_ff @(posedge clk) begin
      if (!rst_n)          cnt[i] <= '0;
      else if (set_i)      cnt[i] <= CW'(WIN);
      else if (busy[i])    cnt[i] <= cnt[i] - 1'b1;
    end

    p_countdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[i] && !set_i) |=> (cnt[i] == CW'($past(cnt[i]) - 1'b1)));

    p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[i] && !set_i) |=> !busy[i]);
  end

  p_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> busy[$past(dst)]);

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy) <= WIN);

  p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!stall && !issue));
endmodule

// File: tb/sim_load_use_interlock.sv
module sim_load_use_interlock;
  logic clk = 0, rst_n = 0;
  logic dec_valid = 0, dec_load = 0, src_a_en = 0, src_b_en = 0, dst_rd_en = 0;
  logic [3:0] src_a = 0, src_b = 0, dst = 0;
  logic stall, issue;
  logic [15:0] busy;

  int tests = 0, fails = 0;
  int rem [16];

  always #5 clk = ~clk;

  load_use_interlock u0 (.*);

  function automatic logic model_stall();
    if (!dec_valid) return 0;
    return (src_a_en && rem[src_a] > 0) || (src_b_en && rem[src_b] > 0) ||
           (dst_rd_en && rem[dst] > 0);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare at mid-cycle, then advance model across one edge
  task automatic step(string tag, output logic st);
    logic ms;
    logic [15:0] mb;
    #1;
    ms = model_stall();
    for (int r = 0; r < 16; r++) mb[r] = rem[r] > 0;
    check(tag, "stall", stall, ms);
    check(tag, "issue", issue, dec_valid && !ms);
    check(tag, "busy", busy, mb);
    st = stall;
    @(posedge clk);
    for (int r = 0; r < 16; r++) if (rem[r] > 0) rem[r]--;
    if (dec_valid && !ms && dec_load) rem[dst] = 3;
    @(negedge clk);
  endtask

  task automatic drive(logic v, logic ld, logic [3:0] a, logic ae, logic [3:0] b,
                       logic be, logic [3:0] d, logic de);
    dec_valid = v; dec_load = ld; src_a = a; src_a_en = ae;
    src_b = b; src_b_en = be; dst = d; dst_rd_en = de;
  endtask

  // hold instruction in decode until it issues; returns stall cycles
  task automatic run(string tag, logic ld, logic [3:0] a, logic ae, logic [3:0] b,
                     logic be, logic [3:0] d, logic de, output int nst);
    logic st;
    nst = 0;
    drive(1, ld, a, ae, b, be, d, de);
    for (int k = 0; k < 10; k++) begin
      step(tag, st);
      if (!st) break;
      nst++;
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle(string tag, int n);
    logic st;
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < n; k++) step(tag, st);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic st;
    for (int r = 0; r < 16; r++) rem[r] = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1: reset state
    idle("R1", 2);

    // R2: busy window exactly 3 cycles, observed with bubbles
    run("R2", 1, 4'd1, 1, 0, 0, 4'd5, 0, n);
    check("R2", "busy r5 after load", busy[5], 1);
    idle("R2", 4);
    check("R2", "r5 free after window", busy[5], 0);

    // R6/R7: stall length 4-d for distance d=1..4, via source A
    for (int d = 1; d <= 4; d++) begin
      run("R6", 1, 4'd2, 1, 0, 0, 4'd6, 0, n);
      for (int f = 1; f < d; f++) run("R6", 0, 4'd9, 1, 4'd10, 1, 4'd11, 1, n);
      run("R7", 0, 4'd6, 1, 4'd0, 0, 4'd12, 0, n);
      check("R6", "stall cycles", n, 4 - d);
      idle("R6", 3);
    end

    // R3: source B dependency
    run("R3", 1, 4'd0, 1, 0, 0, 4'd7, 0, n);
    run("R3", 0, 4'd1, 1, 4'd7, 1, 4'd3, 0, n);
    check("R3", "srcB stall cycles", n, 3);
    idle("R3", 3);

    // R4: target also read (store data / two-address)
    run("R4", 1, 4'd0, 1, 0, 0, 4'd8, 0, n);
    run("R4", 0, 4'd1, 1, 4'd2, 1, 4'd8, 1, n);
    check("R4", "dst-read stall cycles", n, 3);
    idle("R4", 3);

    // R5: disabled fields ignored
    run("R5", 1, 4'd0, 1, 0, 0, 4'd9, 0, n);
    run("R5", 0, 4'd9, 0, 4'd9, 0, 4'd9, 0, n);
    check("R5", "no stall from unread fields", n, 0);
    idle("R5", 3);

    // R8: invalid load does nothing; stalled load does not mark until issue
    drive(0, 1, 4'd0, 1, 0, 0, 4'd4, 0);
    step("R8", st);
    check("R8", "invalid load no mark", busy[4], 0);
    run("R8", 1, 4'd0, 1, 0, 0, 4'd5, 0, n);
    drive(1, 1, 4'd5, 1, 0, 0, 4'd13, 0);
    step("R8", st);
    check("R8", "stalled load no mark", busy[13], 0);
    run("R8", 1, 4'd5, 1, 0, 0, 4'd13, 0, n);
    check("R8", "load marks after issue", busy[13], 1);
    idle("R8", 4);

    // R9: back-to-back load to same reg restarts window
    run("R9", 1, 4'd0, 1, 0, 0, 4'd2, 0, n);
    run("R9", 1, 4'd1, 1, 0, 0, 4'd2, 0, n);
    run("R9", 0, 4'd2, 1, 0, 0, 4'd3, 0, n);
    check("R9", "stall after restart", n, 3);
    idle("R9", 3);

    // R10/R2: loads to every register, three in flight at most
    for (int r = 0; r < 16; r++) begin
      run("R10", 1, 4'(r + 1), 0, 0, 0, 4'(r), 0, n);
      check("R10", "own bit busy", busy[r], 1);
      check("R2", "at most 3 busy", $countones(busy) <= 3, 1);
    end
    idle("R10", 4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule